// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a small in-order processor core with five pipeline stages: fetch, decode with register read, execute, memory access and write-back. It runs a compact integer subset (load word, store word, add-immediate, register add, shift-left-logical, branch-if-equal, jump, and the all-zero no-operation). The complete 32-bit instruction word moves from one pipeline register to the next. Every stage works out its own control signals from the word it holds, so there is no central controller.

The core has no forwarding paths, no interlock and no stall. Software has to place enough independent instructions or no-ops between a result and its use. The register file is written in the middle of the cycle and read at the end of it. This lets an instruction three slots behind a producer see the new value. Branches and jumps are resolved in decode, and the one instruction that follows them always executes.

Both memories are small word arrays inside the block. They are filled through a load port while reset is held. Results become visible on two observation ports: one shows each committed register write, the other shows each store as it passes through the memory stage.

Top module: `pipe5_core`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0 and fills every pipeline register with the all-zero word. While `rst` is high, and for the first three cycles after it falls, `wb_en` and `st_en` stay low. The first instruction executed is the word at word index 0. While `ld_en` is high, `ld_data` is written at a rising edge to word `ld_addr` of the data memory when `ld_dmem` is 1, or of the instruction memory when it is 0.
- R2: Encodings use opcode in bits 31:26, rs in 25:21, rt in 20:16, rd in 15:11, shamt in 10:6 and funct in 5:0. Opcode 0x00 with funct 0x20 writes rs+rt to rd. Opcode 0x00 with funct 0x00 writes rt shifted left by shamt to rd. Opcode 0x08 writes rs plus the sign-extended bits 15:0 to rt.
- R3: Opcode 0x23 loads the data word at byte address rs+sext(imm) into rt. Opcode 0x2B stores rt at that address. A store drives `st_en`, `st_addr` and `st_data` for one cycle and never produces a write-back.
- R4: An instruction fetched in cycle f shows its store on the `st_` ports in cycle f+3 and its register write on the `wb_` ports in cycle f+4. A new instruction enters every cycle.
- R5: A reader placed three or more slots after the writer of a register reads the written value.
- R6: A reader placed one or two slots after the writer of a register reads the value that register held before the write.
- R7: Opcode 0x04 with equal rs and rt redirects fetch to PC+4 of the branch plus sext(imm) shifted left by two. This works with negative offsets. The next sequential instruction (the delay slot) still executes, and the instructions between the slot and the target do not.
- R8: Opcode 0x04 with unequal operands falls through. Opcode 0x02 redirects to the upper four bits of PC+4 of the jump, followed by bits 25:0 and then two zero bits. In both cases the slot instruction executes.
- R9: Register 0 always reads as zero. A write that targets register 0 is dropped and does not raise `wb_en`.
- R10: Any opcode or opcode-0 funct not listed above has no effect on registers, memory or control flow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; pipeline on rising edge, register file written on falling edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Memory preload strobe |
| ld_dmem | input | 1 | Preload target: 1 data memory, 0 instruction memory |
| ld_addr | input | MEM_AW | Preload word index |
| ld_data | input | 32 | Preload word |
| wb_en | output | 1 | A register write commits this cycle |
| wb_reg | output | 5 | Destination register of the commit |
| wb_data | output | 32 | Value written |
| st_en | output | 1 | A store is in the memory stage this cycle |
| st_addr | output | 32 | Byte address of the store |
| st_data | output | 32 | Data being stored |

## Verification
The reference model updates its state once per clock at the instruction that is in decode. It reads registers only from writes whose commit cycle has already come, and it files the register-write result into the slot for four cycles after fetch and the store into the slot for three cycles after fetch. Each cycle, the ports are sampled 15 ns after the rising edge. They are compared against the slot for that cycle, including the empty slots, so an early, late, missing or extra commit fails at the exact cycle where it occurs. When decode holds a taken branch or jump, the model changes the fetch address for the following cycle, which keeps the delay-slot and target timing aligned with the hardware.

// File: rtl/pipe_pkg.sv
package pipe_pkg;
  localparam int XLEN = 32;
  localparam int RAW  = 5;

  typedef logic [XLEN-1:0] word_t;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_JUMP  = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] FN_SLL   = 6'h00;
  localparam logic [5:0] FN_ADD   = 6'h20;

  typedef enum logic [1:0] {ALU_NONE, ALU_ADD, ALU_SHL} alu_op_e;
  typedef enum logic [1:0] {NPC_SEQ, NPC_BR, NPC_JMP} npc_sel_e;

  function automatic word_t sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  // {write enable, destination}; register 0 never enabled
  function automatic logic [RAW:0] wr_dest(input word_t ir);
    logic           en;
    logic [RAW-1:0] r;
    en = 1'b0;
    r  = ir[15:11];
    case (ir[31:26])
      OP_RTYPE: en = (ir[5:0] == FN_ADD) || (ir[5:0] == FN_SLL);
      OP_ADDI, OP_LW: begin
        en = 1'b1;
        r  = ir[20:16];
      end
      default: en = 1'b0;
    endcase
    if (r == '0) en = 1'b0;
    return {en, r};
  endfunction

  function automatic alu_op_e alu_kind(input word_t ir);
    alu_op_e k;
    k = ALU_NONE;
    case (ir[31:26])
      OP_RTYPE: begin
        if (ir[5:0] == FN_ADD)      k = ALU_ADD;
        else if (ir[5:0] == FN_SLL) k = ALU_SHL;
      end
      OP_ADDI, OP_LW, OP_SW: k = ALU_ADD;
      default: k = ALU_NONE;
    endcase
    return k;
  endfunction

  function automatic logic takes_imm(input word_t ir);
    return (ir[31:26] == OP_ADDI) || (ir[31:26] == OP_LW) || (ir[31:26] == OP_SW);
  endfunction

  function automatic logic is_load(input word_t ir);
    return ir[31:26] == OP_LW;
  endfunction

  function automatic logic is_store(input word_t ir);
    return ir[31:26] == OP_SW;
  endfunction

  function automatic logic is_beq(input word_t ir);
    return ir[31:26] == OP_BEQ;
  endfunction
endpackage

// File: rtl/pipe_fetch.sv
module pipe_fetch
  import pipe_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_we,
  input  logic [MEM_AW-1:0] ld_idx,
  input  word_t             ld_data,
  input  npc_sel_e          npc_sel,
  input  word_t             br_tgt,
  input  word_t             jmp_tgt,
  output word_t             pc_o,
  output word_t             ir_o
);
  localparam int DEPTH = 1 << MEM_AW;

  word_t imem [DEPTH];
  word_t pc_q;
  word_t pc_next;

  always_ff @(posedge clk) begin
    if (ld_we) imem[ld_idx] <= ld_data;
  end

  // three-way next-PC select
  always_comb begin
    case (npc_sel)
      NPC_BR:  pc_next = br_tgt;
      NPC_JMP: pc_next = jmp_tgt;
      default: pc_next = pc_q + XLEN'(4);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign pc_o = pc_q;
  assign ir_o = imem[pc_q[MEM_AW+1:2]];
endmodule

// File: rtl/pipe_regfile.sv
module pipe_regfile
  import pipe_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [RAW-1:0] waddr,
  input  word_t          wdata,
  input  logic [RAW-1:0] ra1,
  input  logic [RAW-1:0] ra2,
  output word_t          rd1,
  output word_t          rd2
);
  localparam int NREG = 1 << RAW;

  word_t regs [NREG];

  // mid-cycle write so decode sees it at the closing rising edge
  always_ff @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (waddr != '0)) begin
      regs[waddr] <= wdata;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/pipe_alu.sv
module pipe_alu
  import pipe_pkg::*;
(
  input  alu_op_e    op,
  input  word_t      a,
  input  word_t      b,
  input  logic [4:0] shamt,
  output word_t      y
);
  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SHL: y = b << shamt;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/pipe_dmem.sv
module pipe_dmem
  import pipe_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              ld_we,
  input  logic [MEM_AW-1:0] ld_idx,
  input  word_t             ld_data,
  input  logic              st_we,
  input  logic [MEM_AW-1:0] st_idx,
  input  word_t             st_data,
  input  logic [MEM_AW-1:0] rd_idx,
  output word_t             rd_data
);
  localparam int DEPTH = 1 << MEM_AW;

  word_t dmem [DEPTH];

  always_ff @(posedge clk) begin
    if (ld_we)      dmem[ld_idx] <= ld_data;
    else if (st_we) dmem[st_idx] <= st_data;
  end

  assign rd_data = dmem[rd_idx];
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic              ld_dmem,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [31:0]       ld_data,
  output logic              wb_en,
  output logic [4:0]        wb_reg,
  output logic [31:0]       wb_data,
  output logic              st_en,
  output logic [31:0]       st_addr,
  output logic [31:0]       st_data
);
  // ---------------- fetch ----------------
  word_t    pc_if, if_ir;
  npc_sel_e npc_sel;
  word_t    br_tgt, jmp_tgt;

  pipe_fetch #(.MEM_AW(MEM_AW)) u_fetch (
    .clk     (clk),
    .rst     (rst),
    .ld_we   (ld_en && !ld_dmem),
    .ld_idx  (ld_addr),
    .ld_data (ld_data),
    .npc_sel (npc_sel),
    .br_tgt  (br_tgt),
    .jmp_tgt (jmp_tgt),
    .pc_o    (pc_if),
    .ir_o    (if_ir)
  );

  // ---------------- fetch / decode ----------------
  word_t id_ir, id_pc4;
  always_ff @(posedge clk) begin
    if (rst) begin
      id_ir  <= '0;
      id_pc4 <= '0;
    end else begin
      id_ir  <= if_ir;
      id_pc4 <= pc_if + XLEN'(4);
    end
  end

  word_t rs_val, rt_val;
  logic  wb_we;
  word_t wb_val;
  logic [RAW-1:0] wb_dst;

  pipe_regfile u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (wb_we),
    .waddr (wb_dst),
    .wdata (wb_val),
    .ra1   (id_ir[25:21]),
    .ra2   (id_ir[20:16]),
    .rd1   (rs_val),
    .rd2   (rt_val)
  );

  logic id_is_jump, id_take_br;
  assign id_is_jump = (id_ir[31:26] == OP_JUMP);
  assign id_take_br = is_beq(id_ir) && (rs_val == rt_val);
  assign br_tgt     = id_pc4 + (sext16(id_ir[15:0]) << 2);
  assign jmp_tgt    = {id_pc4[31:28], id_ir[25:0], 2'b00};

  always_comb begin
    if (id_is_jump)      npc_sel = NPC_JMP;
    else if (id_take_br) npc_sel = NPC_BR;
    else                 npc_sel = NPC_SEQ;
  end

  // ---------------- decode / execute ----------------
  word_t ex_ir, ex_a, ex_b;
  always_ff @(posedge clk) begin
    if (rst) begin
      ex_ir <= '0;
      ex_a  <= '0;
      ex_b  <= '0;
    end else begin
      ex_ir <= id_ir;
      ex_a  <= rs_val;
      ex_b  <= rt_val;
    end
  end

  word_t ex_opb, ex_y;
  assign ex_opb = takes_imm(ex_ir) ? sext16(ex_ir[15:0]) : ex_b;

  pipe_alu u_alu (
    .op    (alu_kind(ex_ir)),
    .a     (ex_a),
    .b     (ex_opb),
    .shamt (ex_ir[10:6]),
    .y     (ex_y)
  );

  // ---------------- execute / memory ----------------
  word_t mem_ir, mem_alu, mem_sd;
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_ir  <= '0;
      mem_alu <= '0;
      mem_sd  <= '0;
    end else begin
      mem_ir  <= ex_ir;
      mem_alu <= ex_y;
      mem_sd  <= ex_b;
    end
  end

  word_t mem_rd;
  pipe_dmem #(.MEM_AW(MEM_AW)) u_dmem (
    .clk     (clk),
    .ld_we   (ld_en && ld_dmem),
    .ld_idx  (ld_addr),
    .ld_data (ld_data),
    .st_we   (is_store(mem_ir)),
    .st_idx  (mem_alu[MEM_AW+1:2]),
    .st_data (mem_sd),
    .rd_idx  (mem_alu[MEM_AW+1:2]),
    .rd_data (mem_rd)
  );

  assign st_en   = is_store(mem_ir);
  assign st_addr = mem_alu;
  assign st_data = mem_sd;

  // ---------------- memory / write-back ----------------
  word_t wb_ir;
  always_ff @(posedge clk) begin
    if (rst) begin
      wb_ir  <= '0;
      wb_val <= '0;
    end else begin
      wb_ir  <= mem_ir;
      wb_val <= is_load(mem_ir) ? mem_rd : mem_alu;
    end
  end

  assign {wb_we, wb_dst} = wr_dest(wb_ir);
  assign wb_en   = wb_we;
  assign wb_reg  = wb_dst;
  assign wb_data = wb_val;

  // ---------------- assertions ----------------
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pc_if == '0) && (id_ir == '0) && !wb_en && !st_en);

  p_store_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    st_en |=> !wb_en);

  p_advance_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_ir != '0) |=> (wb_ir == $past(mem_ir)));

  p_slot_kept_r7: assert property (@(posedge clk) disable iff (rst)
    (npc_sel != NPC_SEQ) |=> (id_ir == $past(if_ir)));

  p_target_aligned_r8: assert property (@(posedge clk) disable iff (rst)
    (npc_sel != NPC_SEQ) |=> (pc_if[1:0] == 2'b00));
endmodule

// File: tb/pipe5_core_bench.sv
module pipe5_core_bench;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;
  localparam int NCYC  = 512;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_en = 1'b0;
  logic          ld_dmem = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0]   ld_data = '0;
  logic          wb_en, st_en;
  logic [4:0]    wb_reg;
  logic [31:0]   wb_data, st_addr, st_data;

  pipe5_core #(.MEM_AW(AW)) u_pipe5_core (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_dmem(ld_dmem), .ld_addr(ld_addr),
    .ld_data(ld_data), .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data),
    .st_en(st_en), .st_addr(st_addr), .st_data(st_data)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] prog [DEPTH];
  logic [31:0] mdat [DEPTH];
  logic [31:0] mreg [32];
  logic        x_wb_en [NCYC];
  logic [4:0]  x_wb_reg [NCYC];
  logic [31:0] x_wb_dat [NCYC];
  logic        x_st_en [NCYC];
  logic [31:0] x_st_adr [NCYC];
  logic [31:0] x_st_dat [NCYC];
  int          pq_due [$];
  int          pq_reg [$];
  logic [31:0] pq_val [$];
  logic [31:0] m_pc, m_id, m_id_pc4;
  logic        seen_v [32];
  logic [31:0] seen_r [32];
  logic [31:0] seen_m [DEPTH];
  int          wb_count;
  string       tag;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rd, input logic [4:0] sh, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, sh, fn};
  endfunction

  task automatic clear_prog();
    for (int i = 0; i < DEPTH; i++) begin
      prog[i] = '0;
      mdat[i] = '0;
    end
  endtask

  // behavioural model: one step per cycle, driven by the instruction in decode
  task automatic model_step(input int k);
    logic [31:0] ir, a, b, imm, res, adr, tgt;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd, sh, dst;
    logic        wr, redir;
    while (pq_due.size() > 0 && pq_due[0] <= k) begin
      mreg[pq_reg[0]] = pq_val[0];
      void'(pq_due.pop_front());
      void'(pq_reg.pop_front());
      void'(pq_val.pop_front());
    end
    ir = m_id;
    op = ir[31:26]; rs = ir[25:21]; rt = ir[20:16]; rd = ir[15:11];
    sh = ir[10:6];  fn = ir[5:0];
    a = (rs == 0) ? 32'd0 : mreg[rs];
    b = (rt == 0) ? 32'd0 : mreg[rt];
    imm = {{16{ir[15]}}, ir[15:0]};
    wr = 0; dst = 0; res = 0; redir = 0; tgt = 0;
    case (op)
      6'h00: begin
        if (fn == 6'h20)      begin wr = 1; dst = rd; res = a + b;  end
        else if (fn == 6'h00) begin wr = 1; dst = rd; res = b << sh; end
      end
      6'h08: begin wr = 1; dst = rt; res = a + imm; end
      6'h23: begin adr = a + imm; wr = 1; dst = rt; res = mdat[adr[AW+1:2]]; end
      6'h2B: begin
        adr = a + imm;
        mdat[adr[AW+1:2]] = b;
        x_st_en[k+2] = 1; x_st_adr[k+2] = adr; x_st_dat[k+2] = b;
      end
      6'h04: if (a == b) begin redir = 1; tgt = m_id_pc4 + (imm << 2); end
      6'h02: begin redir = 1; tgt = {m_id_pc4[31:28], ir[25:0], 2'b00}; end
      default: ;
    endcase
    if (wr && dst != 0) begin
      pq_due.push_back(k + 3); pq_reg.push_back(int'(dst)); pq_val.push_back(res);
      x_wb_en[k+3] = 1; x_wb_reg[k+3] = dst; x_wb_dat[k+3] = res;
    end
    m_id     = prog[m_pc[AW+1:2]];
    m_id_pc4 = m_pc + 4;
    m_pc     = redir ? tgt : m_pc + 4;
  endtask

  task automatic compare(input int k);
    chk(tag, $sformatf("cycle %0d wb_en", k), {31'd0, wb_en}, {31'd0, x_wb_en[k]});
    if (x_wb_en[k]) begin
      chk(tag, $sformatf("cycle %0d wb_reg", k), {27'd0, wb_reg}, {27'd0, x_wb_reg[k]});
      chk(tag, $sformatf("cycle %0d wb_data", k), wb_data, x_wb_dat[k]);
    end
    chk(tag, $sformatf("cycle %0d st_en", k), {31'd0, st_en}, {31'd0, x_st_en[k]});
    if (x_st_en[k]) begin
      chk(tag, $sformatf("cycle %0d st_addr", k), st_addr, x_st_adr[k]);
      chk(tag, $sformatf("cycle %0d st_data", k), st_data, x_st_dat[k]);
    end
    if (wb_en) begin
      seen_v[wb_reg] = 1; seen_r[wb_reg] = wb_data; wb_count++;
    end
    if (st_en) seen_m[st_addr[AW+1:2]] = st_data;
  endtask

  task automatic run_prog(input int ncyc);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk); ld_en = 1; ld_dmem = 0; ld_addr = AW'(i); ld_data = prog[i];
      @(negedge clk); ld_dmem = 1; ld_data = mdat[i];
    end
    @(negedge clk); ld_en = 0; ld_dmem = 0;
    @(posedge clk); #5;
    chk("R1", "wb_en during reset", {31'd0, wb_en}, 32'd0);
    chk("R1", "st_en during reset", {31'd0, st_en}, 32'd0);
    for (int i = 0; i < 32; i++) begin
      mreg[i] = 0; seen_v[i] = 0; seen_r[i] = 0;
    end
    for (int i = 0; i < DEPTH; i++) seen_m[i] = 0;
    for (int i = 0; i < NCYC; i++) begin
      x_wb_en[i] = 0; x_wb_reg[i] = 0; x_wb_dat[i] = 0;
      x_st_en[i] = 0; x_st_adr[i] = 0; x_st_dat[i] = 0;
    end
    pq_due.delete(); pq_reg.delete(); pq_val.delete();
    m_pc = 0; m_id = 0; m_id_pc4 = 0; wb_count = 0;
    @(posedge clk); #5; rst = 1'b0;
    #10;
    for (int k = 0; k < ncyc; k++) begin
      model_step(k);
      compare(k);
      @(posedge clk); #15;
    end
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // program 1: load/use spacing, arithmetic, store, register 0, unknown codes
    clear_prog();
    mdat[4] = 32'd100;
    prog[0]  = enc_i(6'h23, 5'd0, 5'd1, 16'd16);        // lw r1
    prog[3]  = enc_i(6'h08, 5'd1, 5'd2, 16'd21);        // addi r2 = r1+21 (R5)
    prog[4]  = enc_i(6'h08, 5'd0, 5'd4, 16'd7);         // r4 = 7
    prog[5]  = enc_r(5'd4, 5'd4, 5'd5, 5'd0, 6'h20);    // stale (R6)
    prog[6]  = enc_r(5'd4, 5'd0, 5'd6, 5'd0, 6'h20);    // stale (R6)
    prog[7]  = enc_r(5'd4, 5'd4, 5'd7, 5'd0, 6'h20);    // fresh (R5)
    prog[10] = enc_r(5'd0, 5'd7, 5'd8, 5'd3, 6'h00);    // sll r8 (R2)
    prog[13] = enc_i(6'h2B, 5'd1, 5'd8, 16'd20);        // sw r8 -> 120 (R3)
    prog[14] = enc_i(6'h08, 5'd0, 5'd0, 16'd9);         // write r0 (R9)
    prog[17] = enc_i(6'h08, 5'd0, 5'd9, 16'd3);         // r9 = r0+3 (R9)
    prog[18] = 32'hFC00_0000;                           // unknown opcode (R10)
    prog[19] = enc_r(5'd1, 5'd1, 5'd10, 5'd0, 6'h22);   // unknown funct (R10)
    tag = "R2 R3 R4 R5 R6 R9 R10";
    run_prog(40);
    chk("R3", "r1 loaded", seen_r[1], 32'd100);
    chk("R5", "r2 after 3-slot gap", seen_r[2], 32'd121);
    chk("R2", "r4 addi", seen_r[4], 32'd7);
    chk("R6", "r5 one-slot stale", seen_r[5], 32'd0);
    chk("R6", "r6 two-slot stale", seen_r[6], 32'd0);
    chk("R5", "r7 three-slot fresh", seen_r[7], 32'd14);
    chk("R2", "r8 shift", seen_r[8], 32'd112);
    chk("R3", "mem[120]", seen_m[30], 32'd112);
    chk("R9", "r0 never committed", {31'd0, seen_v[0]}, 32'd0);
    chk("R9", "r9 reads r0 as zero", seen_r[9], 32'd3);
    chk("R10", "r10 untouched", {31'd0, seen_v[10]}, 32'd0);
    chk("R10", "commit count", wb_count, 32'd8);

    // program 2: taken/untaken branch, jump, slots, backward loop
    clear_prog();
    prog[0]  = enc_i(6'h08, 5'd0, 5'd1, 16'd5);
    prog[1]  = enc_i(6'h08, 5'd0, 5'd2, 16'd5);
    prog[2]  = enc_i(6'h08, 5'd0, 5'd3, 16'd9);
    prog[4]  = enc_i(6'h04, 5'd1, 5'd2, 16'd3);         // taken -> 32 (R7)
    prog[5]  = enc_i(6'h08, 5'd0, 5'd4, 16'd1);         // slot
    prog[6]  = enc_i(6'h08, 5'd0, 5'd5, 16'd2);         // skipped
    prog[7]  = enc_i(6'h08, 5'd0, 5'd5, 16'd3);         // skipped
    prog[8]  = enc_i(6'h04, 5'd1, 5'd3, 16'd5);         // not taken (R8)
    prog[9]  = enc_i(6'h08, 5'd0, 5'd6, 16'd4);         // slot
    prog[10] = {6'h02, 26'd15};                         // jump -> 60 (R8)
    prog[11] = enc_i(6'h08, 5'd0, 5'd7, 16'd6);         // slot
    prog[12] = enc_i(6'h08, 5'd0, 5'd8, 16'd77);        // skipped
    prog[15] = enc_i(6'h2B, 5'd0, 5'd6, 16'd40);        // sw r6 -> 40
    prog[16] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFFE);      // back to 60 (R7)
    prog[17] = enc_i(6'h08, 5'd11, 5'd11, 16'd1);       // slot, counts
    tag = "R4 R7 R8";
    run_prog(40);
    chk("R7", "slot r4", seen_r[4], 32'd1);
    chk("R7", "r5 skipped", {31'd0, seen_v[5]}, 32'd0);
    chk("R8", "slot r6", seen_r[6], 32'd4);
    chk("R8", "slot r7", seen_r[7], 32'd6);
    chk("R8", "r8 skipped", {31'd0, seen_v[8]}, 32'd0);
    chk("R8", "store at jump target", seen_m[10], 32'd4);
    chk("R7", "backward loop ran", {31'd0, (seen_r[11] >= 32'd2)}, 32'd1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule